// File: doc/BRIEF.md
# Three-Wire Serial Bus Master

This block is a master for a three-wire serial bus made of an active-high chip select, a serial clock that the block generates, and one data line that carries traffic in both directions. A host sets up the interface through a small control register that holds an enable bit and a 3-bit clock-rate code. Writing a 16-bit packet word then launches one frame. The upper seven bits of the word are a slave register address. Bit 8 selects the direction, and the low byte is the data to send.

During a write frame the master drives every bit. During a read frame it drives only the address and direction bits. It then stops driving the data line and shifts the slave's reply byte into a read-data register. The host polls the busy flag and reads that register once busy falls. The data line is split into output, output-enable and input pins, so the pad can be placed outside the block.

Top module: `tw_master`

## Requirements
- R1: After reset, busy, chip select, serial clock and data output enable are all 0 and the enable bit is clear, so a packet write has no effect until the interface is enabled.
- R2: A packet write while the interface is enabled and idle raises busy and chip select on the next core clock. Both stay high for exactly 33×H core clocks, where H = 2^code, and then fall together.
- R3: The serial clock idles low and has a period of 2×H core clocks, so codes 0 to 7 give dividers 2 to 256. A frame has exactly 16 pulses, and the first rising edge comes H clocks after busy rises.
- R4: The bit on the data line at the i-th rising edge (i = 0..15) is bit 15−i of the packet word. Bits 15:9 are the address, bit 8 is the direction (0 = write, 1 = read), and bits 7:0 are the data, sent most significant bit first.
- R5: In a write frame (bit 8 = 0), the output enable is high for all 16 pulses. It stays high until chip select falls and drops in the same cycle.
- R6: In a read frame (bit 8 = 1), the output enable drops at the falling edge that ends the direction bit. The data line is sampled on the falling edges of pulses 8 to 15, and the result is assembled MSB first into the read-data output when busy falls. A write frame leaves the read data unchanged.
- R7: A packet write while busy is set is ignored, and the frame in progress continues unchanged.
- R8: The clock-rate code is captured when a frame starts. A rate change written during the frame does not alter its timing.
- R9: A control write that clears the enable bit aborts any frame. By the next clock, busy, chip select, serial clock and output enable are 0, and the read data is left unchanged.
- R10: When a control write and a packet write fall in the same cycle, the control write applies first. A write that disables blocks the start. A write that enables lets the frame start at the newly written rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable bit value for the control write |
| ctl_rate | input | 3 | Clock-rate code for the control write |
| pkt_wr | input | 1 | Packet register write strobe; starts a frame |
| pkt_word | input | 16 | Packet word: address, direction, data |
| busy | output | 1 | High while a frame is in progress |
| rd_data | output | 8 | Byte captured by the last completed read frame |
| cs | output | 1 | Chip select, active high |
| sclk | output | 1 | Serial clock, idles low |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input value |

## Verification
Two events can fall in the same cycle. A control write can coincide with a packet write, and a packet write can arrive while a frame is already running. The bench drives a disabling control write on the same edge as a packet write and expects busy to stay low. It also drives an enabling write with a new rate on the same edge as a packet write, and expects a frame whose length and clock period follow the new rate. Packet writes and rate changes injected mid-frame are judged by checking that the serialized bits, the pulse spacing and the busy length all still match the original word and rate.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tw_clkdiv.sv
module tw_clkdiv #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int MAX_SHIFT = (1 << RATE_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   half_len;
  logic [CNT_W:0]   half_m1;

  always_comb begin
    half_len = {{CNT_W{1'b0}}, 1'b1} << rate;
    half_m1  = half_len - 1'b1;
    tick     = run && ({1'b0, cnt_q} == half_m1);
    cnt_d    = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} < half_len)); // R3
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int IDX_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  output logic             active,
  output logic             sclk,
  output logic             fall,
  output logic             done,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int LAST_PH = 2 * FRAME_W;
  localparam int PH_W    = $clog2(LAST_PH + 1);

  seq_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            sclk_q, sclk_d;
  logic            at_last;

  always_comb begin
    at_last = (ph_q == PH_W'(LAST_PH));
    st_d    = st_q;
    ph_d    = ph_q;
    sclk_d  = sclk_q;
    if (abort) begin
      st_d   = SEQ_IDLE;
      ph_d   = '0;
      sclk_d = 1'b0;
    end else if (st_q == SEQ_IDLE) begin
      if (start) begin
        st_d   = SEQ_SHIFT;
        ph_d   = '0;
        sclk_d = 1'b0;
      end
    end else if (tick) begin
      if (at_last) begin
        st_d   = SEQ_IDLE;
        ph_d   = '0;
        sclk_d = 1'b0;
      end else begin
        ph_d   = ph_q + 1'b1;
        sclk_d = ~ph_q[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign active  = (st_q == SEQ_SHIFT);
  assign sclk    = sclk_q;
  assign fall    = active && tick && ph_q[0];
  assign done    = active && tick && at_last;
  assign bit_idx = IDX_W'(ph_q >> 1);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk_q); // R3
  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> sclk_q); // R3
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_W'(LAST_PH)); // R2
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = ADDR_W + 1 + DATA_W,
  parameter int IDX_W   = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               active,
  input  logic [FRAME_W-1:0] frame,
  input  logic               fall,
  input  logic               done,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic               sdio_i,
  output logic               tx,
  output logic               oe,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [IDX_W-1:0] DIR_IDX  = IDX_W'(ADDR_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               tx_q, tx_d;
  logic               oe_q, oe_d;
  logic               rdf_q, rdf_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;

  always_comb begin
    sh_d    = sh_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    rdf_d   = rdf_q;
    rdata_d = rdata_q;
    if (abort) begin
      oe_d = 1'b0;
    end else if (start) begin
      sh_d  = frame;
      tx_d  = frame[FRAME_W-1];
      oe_d  = 1'b1;
      rdf_d = frame[DATA_W];
    end else begin
      if (fall) begin
        sh_d = {sh_q[FRAME_W-2:0], sdio_i};
        if (bit_idx != LAST_IDX) tx_d = sh_q[FRAME_W-2];
        if (rdf_q && (bit_idx == DIR_IDX)) oe_d = 1'b0;
      end
      if (done) begin
        oe_d = 1'b0;
        if (rdf_q) rdata_d = sh_q[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      tx_q    <= 1'b0;
      oe_q    <= 1'b0;
      rdf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      oe_q    <= oe_d;
      rdf_q   <= rdf_d;
      rdata_q <= rdata_d;
    end
  end

  assign tx    = tx_q;
  assign oe    = oe_q;
  assign rdata = rdata_q;

  AST_OE_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> active); // R5
  AST_RDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> $stable(rdata_q)); // R6
endmodule

// File: rtl/tw_master.sv
module tw_master
  import tw_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  parameter int RATE_W  = 3,
  parameter int FRAME_W = ADDR_W + 1 + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_en,
  input  logic [RATE_W-1:0]  ctl_rate,
  input  logic               pkt_wr,
  input  logic [FRAME_W-1:0] pkt_word,
  output logic               busy,
  output logic [DATA_W-1:0]  rd_data,
  output logic               cs,
  output logic               sclk,
  output logic               sdio_o,
  output logic               sdio_oe,
  input  logic               sdio_i
);
  localparam int IDX_W = $clog2(FRAME_W);

  logic              en_q, en_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [RATE_W-1:0] rate_lat_q, rate_lat_d;
  logic              eff_en;
  logic [RATE_W-1:0] eff_rate;
  logic              start, abort;
  logic              tick, active, fall, done;
  logic [IDX_W-1:0]  bit_idx;

  always_comb begin
    eff_en     = ctl_wr ? ctl_en : en_q;
    eff_rate   = ctl_wr ? ctl_rate : rate_q;
    abort      = ctl_wr && !ctl_en;
    start      = pkt_wr && eff_en && !active;
    en_d       = eff_en;
    rate_d     = eff_rate;
    rate_lat_d = start ? eff_rate : rate_lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      rate_q     <= '0;
      rate_lat_q <= '0;
    end else begin
      en_q       <= en_d;
      rate_q     <= rate_d;
      rate_lat_q <= rate_lat_d;
    end
  end

  tw_clkdiv #(.RATE_W(RATE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .rate  (rate_lat_q),
    .tick  (tick)
  );

  tw_seq #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .abort   (abort),
    .tick    (tick),
    .active  (active),
    .sclk    (sclk),
    .fall    (fall),
    .done    (done),
    .bit_idx (bit_idx)
  );

  tw_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .abort   (abort),
    .active  (active),
    .frame   (pkt_word),
    .fall    (fall),
    .done    (done),
    .bit_idx (bit_idx),
    .sdio_i  (sdio_i),
    .tx      (sdio_o),
    .oe      (sdio_oe),
    .rdata   (rd_data)
  );

  assign busy = active;
  assign cs   = active;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cs && sdio_oe)); // R2
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !sclk && !sdio_oe)); // R9
  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rate_lat_q)); // R8
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en_q && !ctl_wr) |=> !busy); // R1
endmodule

// File: tb/tw_master_tb.sv
module tw_master_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_en = 1'b0;
  logic [2:0]  ctl_rate = '0;
  logic        pkt_wr = 1'b0;
  logic [15:0] pkt_word = '0;
  logic        busy, cs, sclk, sdio_o, sdio_oe;
  logic        sdio_i = 1'b0;
  logic [7:0]  rd_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rd_model = '0;

  always #(CLK_P/2) clk = ~clk;

  tw_master u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_rate(ctl_rate),
    .pkt_wr(pkt_wr), .pkt_word(pkt_word), .busy(busy), .rd_data(rd_data), .cs(cs),
    .sclk(sclk), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  function automatic int half_of(input int code);
    return 1 << code;
  endfunction

  function automatic int frame_len(input int code);
    return 33 * half_of(code);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic en, input int code);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = en; ctl_rate = 3'(code);
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // mode: 0 plain, 1 packet write mid-frame (R7), 2 rate write mid-frame (R8),
  //       3 abort mid-frame (R9), 4 enable written together with the packet (R10)
  task automatic run_xfer(input logic [15:0] w, input int code, input int mode, input logic [7:0] sb);
    int h = half_of(code);
    int cyc = 0, rises = 0, r0 = -1, r1 = -1, abort_at = 5 * h + 1;
    logic [15:0] seen = '0;
    bit oe_ok = 1, cs_ok = 1, end_ok = 1;
    logic prev = 1'b0;
    bit is_rd = w[8];
    logic [7:0] prior = rd_model;
    @(negedge clk);
    pkt_wr = 1'b1; pkt_word = w;
    if (mode == 4) begin ctl_wr = 1'b1; ctl_en = 1'b1; ctl_rate = 3'(code); end
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cs !== busy) cs_ok = 0;
      if (mode == 3 && cyc == abort_at + 1) begin
        chk(!busy && !cs && !sclk && !sdio_oe, "R9 abort idle", {busy, cs, sclk, sdio_oe}, 0);
        chk(rd_data == prior, "R9 rd_data kept", rd_data, prior);
        break;
      end
      if (!busy) begin
        if (sdio_oe !== 1'b0 || sclk !== 1'b0) end_ok = 0;
        break;
      end
      if (sclk && !prev) begin
        if (rises < 16) seen[15-rises] = sdio_o;
        if (sdio_oe !== (!is_rd || rises < 8)) oe_ok = 0;
        if (is_rd && rises >= 8 && rises < 16) sdio_i = sb[15-rises];
        if (rises == 0) r0 = cyc;
        if (rises == 1) r1 = cyc;
        rises++;
      end
      prev = sclk;
      pkt_wr = 1'b0; ctl_wr = 1'b0;
      if (mode == 1 && cyc == 3) begin pkt_wr = 1'b1; pkt_word = ~w; end
      if (mode == 2 && cyc == 3) begin ctl_wr = 1'b1; ctl_en = 1'b1; ctl_rate = 3'((code + 1) % 8); end
      if (mode == 3 && cyc == abort_at) begin ctl_wr = 1'b1; ctl_en = 1'b0; end
      if (cyc > 20000) break;
    end
    pkt_wr = 1'b0; ctl_wr = 1'b0;
    if (mode == 3) return;
    chk(cyc - 1 == frame_len(code), (mode == 2) ? "R8 frame length" : "R2 frame length", cyc - 1, frame_len(code));
    chk(cs_ok, "R2 cs follows busy", 0, 1);
    chk(rises == 16, "R3 pulse count", rises, 16);
    chk(r0 == h + 1 && r1 - r0 == 2 * h, "R3 clock timing", r1 - r0, 2 * h);
    if (is_rd) begin
      chk(seen[15:8] == w[15:8], "R4 header bits", seen[15:8], w[15:8]);
      chk(oe_ok, "R6 release after direction bit", 0, 1);
      chk(rd_data == sb, "R6 read capture", rd_data, sb);
      rd_model = sb;
    end else begin
      chk(seen == w, (mode == 1) ? "R7 R4 serialized word" : "R4 serialized word", seen, w);
      chk(oe_ok && end_ok, "R5 driven through D0", 0, 1);
      chk(rd_data == prior, "R6 write keeps rd_data", rd_data, prior);
    end
    if (mode == 4) chk(1, "R10 enable with packet", 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cs && !sclk && !sdio_oe, "R1 reset state", {busy, cs, sclk, sdio_oe}, 0);
    // R1: packet write while disabled
    pkt_word = 16'h1234; pkt_wr = 1'b1;
    @(negedge clk); pkt_wr = 1'b0;
    chk(!busy && !cs, "R1 disabled ignores packet", busy, 0);
    @(negedge clk);
    chk(!busy && !sclk, "R1 disabled stays idle", busy, 0);
    // R10: enable written in same cycle as packet
    run_xfer(16'hA55A, 1, 4, 8'h00);
    // R10: disable written in same cycle as packet
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = 1'b0; pkt_wr = 1'b1; pkt_word = 16'h0F0F;
    @(negedge clk);
    ctl_wr = 1'b0; pkt_wr = 1'b0;
    chk(!busy && !cs, "R10 disable blocks start", busy, 0);
    set_ctl(1'b1, 0);
    run_xfer(16'hFE00, 0, 0, 8'h00);
    run_xfer(16'h81FF, 0, 0, 8'h5A);
    set_ctl(1'b1, 7);
    run_xfer(16'h0155, 7, 0, 8'hC3);
    set_ctl(1'b1, 2);
    run_xfer(16'h4E7E, 2, 1, 8'h00);
    run_xfer(16'h2301, 2, 1, 8'h96);
    run_xfer(16'h6C3C, 2, 2, 8'h00);
    set_ctl(1'b1, 2);
    run_xfer(16'h7FAA, 2, 3, 8'h11);
    set_ctl(1'b1, 3);
    run_xfer(16'h3381, 3, 0, 8'hE7);
    for (int k = 0; k < 40; k++) begin
      int code = $urandom_range(0, 5);
      logic [15:0] w = 16'($urandom);
      logic [7:0] sb = 8'($urandom);
      set_ctl(1'b1, code);
      run_xfer(w, code, 0, sb);
    end
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule